// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Engine

This block is the bit-level front end of a background debug port that shares one pseudo-open-drain pin with an external host. It samples the pin on the local debug clock and finds host-generated falling edges. Each accepted edge opens a fixed-length bit window. In receive direction the block reads the pin at a fixed offset inside the window and packs the bits into bytes, most significant bit first. In transmit direction it sends a loaded byte, one bit per host-opened window. A 0 is sent by holding the line low. A 1 is sent by driving a one-cycle high pulse that speeds up the rising edge.

The host paces every bit, so the receive side cannot be throttled. The receive output is a valid/ready stream with a single holding register. `rx_valid` stays high and `rx_data` stays stable until `rx_ready` is seen high at a clock edge. A byte that completes while the holding register is still full and not being drained in that cycle is discarded. The transmit input is a valid/ready stream. A byte is taken at a clock edge where `tx_valid` and `tx_ready` are both high, and that load also selects transmit direction for the next eight windows. The host must not expect a byte to be taken before `tx_ready` is high, and `tx_ready` does not depend on `tx_valid`.

If no host edge is accepted for a long stretch, the block raises a one-cycle `abort_o` and drops any partly received or partly sent byte. The command layer above uses this pulse to cancel the command without touching memory or mode.

Top module: `sdbg_bit_engine`

## Requirements
- R1: An accepted falling edge starts a window of BIT_CYCLES (16) cycles. The edge is seen in window cycle 0, and window cycles 1 to 15 follow. Falling edges seen in cycles 1 to 15 are ignored. The earliest edge that can start the next window is seen in cycle 16.
- R2: The pin passes through SYNC_STAGES (2) flip-flops. An edge is seen in the cycle where the synchronized level is 0 and the level one stage later was 1.
- R3: In a receive window, the synchronized level in window cycle SAMPLE_AT (10) is shifted in as the next bit. The first bit received is bit 7 of the byte. After eight bits, the byte is presented on `rx_data`, with `rx_valid` high from the following cycle.
- R4: `rx_valid` and `rx_data` hold until `rx_ready` is high at a clock edge. A byte that completes while the holding register is full and `rx_ready` is low is dropped.
- R5: `pin_oe` is low whenever no transmit byte is loaded, which includes every receive window and all idle time.
- R6: `tx_ready` is high only when all of these hold: no transmit byte is loaded, no received bits are pending, no window is open, no edge is seen this cycle, and no abort is raised. The loaded byte is sent over the next eight windows, bit 7 first. After that the block returns to receive direction.
- R7: When the transmit bit is 1, `pin_oe` and `pin_o` are both high in window cycle SPEEDUP_AT (7) only, and `pin_oe` is low in every other cycle of that window.
- R8: When the transmit bit is 0, `pin_oe` is high and `pin_o` is low in window cycles 1 through DRIVE0_END (11). The line is released from cycle 12.
- R9: If TIMEOUT cycles pass after the last accepted edge with no further edge, `abort_o` is high for exactly one cycle. The pulse comes in the cycle that lies TIMEOUT cycles after that edge. It clears any pending received bits and any loaded transmit byte. It does not repeat until a new edge is accepted, and it does not touch the holding register.
- R10: An edge seen in the cycle of an abort does not start a window, and `tx_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Level on the shared debug pin |
| pin_o | output | 1 | Level driven onto the pin when enabled |
| pin_oe | output | 1 | Pin drive enable |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W | Received byte |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | Engine can load a transmit byte |
| tx_data | input | DATA_W | Byte to send to the host |
| abort_o | output | 1 | One-cycle inactivity abort |

## Verification
The bench builds the engine with TIMEOUT set to 40 and keeps the default bit timing. At that setting, aborts during partly received bytes, during partly sent bytes and in idle time all happen many times in a short run. Host frames with random low times and random spacing also reach the cycles around the timeout limit, where a new edge and the abort compete. Spacing below 16 cycles reaches the ignored-edge case, and exactly 16 cycles reaches the earliest accepted edge. Holding `rx_ready` low across two bytes reaches the drop case.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

  // direction of the window currently framed by the host
  typedef enum logic {
    DIR_TO_TARGET = 1'b0,
    DIR_TO_HOST   = 1'b1
  } sdbg_dir_e;

  // line action requested by the transmit side in one cycle
  typedef enum logic [1:0] {
    LINE_RELEASE = 2'd0,
    LINE_LOW     = 2'd1,
    LINE_PULSE   = 2'd2
  } sdbg_line_e;

endpackage

// File: rtl/sdbg_edge_sync.sv
module sdbg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/sdbg_bit_timer.sv
module sdbg_bit_timer #(
  parameter int BIT_CYCLES = 16,
  parameter int TIMEOUT    = 512,
  localparam int PH_W      = $clog2(BIT_CYCLES),
  localparam int TM_W      = $clog2(TIMEOUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fall_i,
  output logic            win_active_o,
  output logic [PH_W-1:0] phase_o,
  output logic            accept_o,
  output logic            abort_o
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYCLES - 1);
  localparam logic [TM_W-1:0] TM_END  = TM_W'(TIMEOUT);

  logic            active_q;
  logic [PH_W-1:0] ph_q;
  logic [TM_W-1:0] idle_q;
  logic            armed_q;

  assign abort_o      = armed_q && (idle_q == TM_END);
  assign accept_o     = fall_i && !active_q && !abort_o;
  assign win_active_o = active_q;
  assign phase_o      = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      idle_q   <= '0;
      armed_q  <= 1'b0;
    end else if (abort_o) begin
      armed_q <= 1'b0;
      idle_q  <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      ph_q     <= PH_W'(1);
      idle_q   <= TM_W'(1);
      armed_q  <= 1'b1;
    end else begin
      if (active_q) begin
        if (ph_q == PH_LAST) begin
          active_q <= 1'b0;
          ph_q     <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
      if (armed_q) idle_q <= idle_q + 1'b1;
    end
  end

  AST_WIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && ph_q != PH_LAST) |=> (active_q && ph_q == PH_W'($past(ph_q) + 1'b1))); // R1
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && ph_q == PH_LAST) |=> !active_q); // R1
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o); // R9

endmodule

// File: rtl/sdbg_rx_shift.sv
module sdbg_rx_shift #(
  parameter int DATA_W    = 8,
  parameter int PH_W      = 4,
  parameter int SAMPLE_AT = 10,
  localparam int CNT_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_active_i,
  input  logic [PH_W-1:0]   phase_i,
  input  sdbg_pkg::sdbg_dir_e dir_i,
  input  logic              level_i,
  input  logic              abort_i,
  input  logic              rx_ready_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              empty_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [PH_W-1:0]  PH_SAMP  = PH_W'(SAMPLE_AT);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic              hold_v_q;
  logic [DATA_W-1:0] hold_d_q;
  logic              take_bit;
  logic              byte_done;

  assign take_bit  = win_active_i && (dir_i == sdbg_pkg::DIR_TO_TARGET) && (phase_i == PH_SAMP);
  assign sh_next   = {sh_q[DATA_W-2:0], level_i};
  assign byte_done = take_bit && (cnt_q == CNT_LAST);
  assign empty_o   = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (abort_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (take_bit) begin
      sh_q  <= sh_next;
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else if (byte_done && (!hold_v_q || rx_ready_i)) begin
      hold_v_q <= 1'b1;
      hold_d_q <= sh_next;
    end else if (rx_ready_i) begin
      hold_v_q <= 1'b0;
    end
  end

  assign rx_valid_o = hold_v_q;
  assign rx_data_o  = hold_d_q;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v_q && !rx_ready_i) |=> (hold_v_q && $stable(hold_d_q))); // R4
  AST_ABORT_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> empty_o); // R9

endmodule

// File: rtl/sdbg_tx_shift.sv
module sdbg_tx_shift #(
  parameter int DATA_W     = 8,
  parameter int PH_W       = 4,
  parameter int BIT_CYCLES = 16,
  parameter int SPEEDUP_AT = 7,
  parameter int DRIVE0_END = 11,
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_active_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              fall_i,
  input  logic              abort_i,
  input  logic              rx_empty_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output sdbg_pkg::sdbg_dir_e dir_o,
  output logic              pin_o,
  output logic              pin_oe
);

  import sdbg_pkg::*;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(BIT_CYCLES - 1);
  localparam logic [PH_W-1:0]  PH_PULSE = PH_W'(SPEEDUP_AT);
  localparam logic [PH_W-1:0]  PH_D0END = PH_W'(DRIVE0_END);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              load;
  logic              cur_bit;
  sdbg_line_e        line;

  assign tx_ready_o = !busy_q && rx_empty_i && !win_active_i && !fall_i && !abort_i;
  assign load       = tx_valid_i && tx_ready_o;
  assign cur_bit    = sh_q[DATA_W-1];
  assign dir_o      = busy_q ? DIR_TO_HOST : DIR_TO_TARGET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= tx_data_i;
    end else if (win_active_i && busy_q && phase_i == PH_LAST) begin
      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      if (cnt_q == CNT_LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    line = LINE_RELEASE;
    if (win_active_i && busy_q) begin
      if (cur_bit && phase_i == PH_PULSE)        line = LINE_PULSE;
      else if (!cur_bit && phase_i <= PH_D0END)  line = LINE_LOW;
    end
  end

  assign pin_oe = (line != LINE_RELEASE);
  assign pin_o  = (line == LINE_PULSE);

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !win_active_i); // R6

endmodule

// File: rtl/sdbg_bit_engine.sv
module sdbg_bit_engine #(
  parameter int DATA_W      = 8,
  parameter int BIT_CYCLES  = 16,
  parameter int SAMPLE_AT   = 10,
  parameter int SPEEDUP_AT  = 7,
  parameter int DRIVE0_END  = 11,
  parameter int TIMEOUT     = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              abort_o
);

  localparam int PH_W = $clog2(BIT_CYCLES);

  logic                level;
  logic                fall;
  logic                win_active;
  logic [PH_W-1:0]     phase;
  logic                accept;
  logic                abort;
  logic                rx_empty;
  sdbg_pkg::sdbg_dir_e dir;

  sdbg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .level_o(level), .fall_o(fall)
  );

  sdbg_bit_timer #(.BIT_CYCLES(BIT_CYCLES), .TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .win_active_o(win_active),
    .phase_o(phase), .accept_o(accept), .abort_o(abort)
  );

  sdbg_rx_shift #(.DATA_W(DATA_W), .PH_W(PH_W), .SAMPLE_AT(SAMPLE_AT)) u_rx (
    .clk(clk), .rst_n(rst_n), .win_active_i(win_active), .phase_i(phase),
    .dir_i(dir), .level_i(level), .abort_i(abort), .rx_ready_i(rx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .empty_o(rx_empty)
  );

  sdbg_tx_shift #(.DATA_W(DATA_W), .PH_W(PH_W), .BIT_CYCLES(BIT_CYCLES),
                  .SPEEDUP_AT(SPEEDUP_AT), .DRIVE0_END(DRIVE0_END)) u_tx (
    .clk(clk), .rst_n(rst_n), .win_active_i(win_active), .phase_i(phase),
    .fall_i(fall), .abort_i(abort), .rx_empty_i(rx_empty),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .dir_o(dir), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  assign abort_o = abort;

  AST_SPEEDUP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && pin_o) |=> !pin_oe); // R7
  AST_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pin_oe) && !$past(pin_o)) |-> (phase == PH_W'(DRIVE0_END + 1))); // R8
  AST_QUIET_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (win_active && dir == sdbg_pkg::DIR_TO_TARGET) |-> !pin_oe); // R5
  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (win_active && phase == PH_W'(1))); // R1

endmodule

// File: tb/sdbg_bit_engine_tb_top.sv
module sdbg_bit_engine_tb_top;

  localparam int DW = 8, BITC = 16, SAMP = 10, SPD = 7, D0 = 11, TMO = 40, SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_lvl = 1'b1;
  logic pin_i, pin_o, pin_oe, rx_valid, rx_ready, tx_valid, tx_ready, abort_o;
  logic [DW-1:0] rx_data, tx_data;

  always #5 clk = ~clk;

  // wired line: host pulls low, target may pull low; a high pulse needs no wiring
  assign pin_i = host_lvl & ~(pin_oe & ~pin_o);

  sdbg_bit_engine #(.DATA_W(DW), .BIT_CYCLES(BITC), .SAMPLE_AT(SAMP), .SPEEDUP_AT(SPD),
                    .DRIVE0_END(D0), .TIMEOUT(TMO), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .abort_o(abort_o)
  );

  int vectors = 0, misses = 0;
  bit done = 0;

  // behavioural reference state
  bit sq[$];
  int m_prev, m_act, m_ph, m_tmo, m_arm, m_rxc, m_rxsh, m_hv, m_hd, m_txb, m_txc, m_txsh;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    sq.delete();
    for (int i = 0; i < SYNC; i++) sq.push_back(1'b1);
    m_prev = 1; m_act = 0; m_ph = 0; m_tmo = 0; m_arm = 0; m_rxc = 0; m_rxsh = 0;
    m_hv = 0; m_hd = 0; m_txb = 0; m_txc = 0; m_txsh = 0;
  endtask

  always @(negedge clk) begin
    int snow, fall, e_ab, e_acc, e_txr, bitv, e_oe, e_o, samp, push, nsh;
    int n_act, n_ph, n_tmo, n_arm, n_rxc, n_rxsh, n_hv, n_hd, n_txb, n_txc, n_txsh;
    if (!rst_n) model_reset();
    snow  = sq[SYNC-1];
    fall  = (m_prev == 1 && snow == 0);
    e_ab  = (m_arm == 1 && m_tmo == TMO);
    e_acc = fall && !m_act && !e_ab;
    e_txr = !m_txb && m_rxc == 0 && !m_act && !fall && !e_ab;
    bitv  = (m_txsh >> 7) & 1;
    e_oe  = m_act && m_txb && ((bitv == 0 && m_ph <= D0) || (bitv == 1 && m_ph == SPD));
    e_o   = e_oe && bitv;
    if (!done) begin
      chk("R5/R7/R8 pin_oe", pin_oe, e_oe);
      chk("R7/R8 pin_o", pin_o, e_o);
      chk("R3/R4 rx_valid", rx_valid, m_hv);
      if (m_hv) chk("R1/R2/R3 rx_data", rx_data, m_hd);
      chk("R6/R10 tx_ready", tx_ready, e_txr);
      chk("R9 abort_o", abort_o, e_ab);
    end
    if (rst_n) begin
      n_act = m_act; n_ph = m_ph; n_tmo = m_tmo; n_arm = m_arm; n_rxc = m_rxc; n_rxsh = m_rxsh;
      n_hv = m_hv; n_hd = m_hd; n_txb = m_txb; n_txc = m_txc; n_txsh = m_txsh;
      push = 0; nsh = 0;
      if (e_ab) begin
        n_arm = 0; n_tmo = 0; n_rxc = 0; n_rxsh = 0; n_txb = 0; n_txc = 0; n_txsh = 0;
      end else begin
        if (e_acc) begin
          n_act = 1; n_ph = 1; n_tmo = 1; n_arm = 1;
        end else begin
          if (m_act) begin
            if (m_ph == BITC - 1) begin n_act = 0; n_ph = 0; end
            else n_ph = m_ph + 1;
          end
          if (m_arm) n_tmo = m_tmo + 1;
        end
        samp = m_act && !m_txb && m_ph == SAMP;
        if (samp) begin
          nsh = ((m_rxsh << 1) | snow) & 255;
          n_rxsh = nsh;
          if (m_rxc == DW - 1) begin n_rxc = 0; push = 1; end
          else n_rxc = m_rxc + 1;
        end
        if (tx_valid && e_txr) begin
          n_txb = 1; n_txc = 0; n_txsh = tx_data;
        end else if (m_act && m_txb && m_ph == BITC - 1) begin
          n_txsh = (m_txsh << 1) & 255;
          if (m_txc == DW - 1) begin n_txb = 0; n_txc = 0; end
          else n_txc = m_txc + 1;
        end
      end
      if (push && (!m_hv || rx_ready)) begin n_hv = 1; n_hd = nsh; end
      else if (rx_ready) n_hv = 0;
      sq.push_front(pin_i);
      m_prev = sq.pop_back();
      m_act = n_act; m_ph = n_ph; m_tmo = n_tmo; m_arm = n_arm; m_rxc = n_rxc; m_rxsh = n_rxsh;
      m_hv = n_hv; m_hd = n_hd; m_txb = n_txb; m_txc = n_txc; m_txsh = n_txsh;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(int low, int period);
    host_lvl = 1'b0; cyc(low);
    host_lvl = 1'b1; cyc(period - low);
  endtask

  task automatic send_byte(logic [7:0] b, int period); // R3: bit 7 first
    for (int i = 7; i >= 0; i--) frame(b[i] ? 4 : 13, period);
  endtask

  task automatic load_tx(logic [7:0] b); // R6
    tx_data = b; tx_valid = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  initial begin
    rx_ready = 1'b1; tx_valid = 1'b0; tx_data = '0;
    model_reset();
    cyc(3); rst_n = 1'b1; cyc(5);                     // reset state checked every cycle
    send_byte(8'hA5, 18); cyc(4);                     // R3 basic receive
    rx_ready = 1'b0;
    send_byte(8'h5A, 18); send_byte(8'hC3, 18);      // R4 second byte dropped
    cyc(3); rx_ready = 1'b1; cyc(3);
    for (int i = 7; i >= 0; i--) begin               // R1 edges inside window ignored
      host_lvl = 0; cyc(2); host_lvl = 1; cyc(2); host_lvl = 0; cyc(2);
      host_lvl = (8'h96 >> i) & 1; cyc(7); host_lvl = 1; cyc(5);
    end
    cyc(4);
    send_byte(8'h3B, 16); cyc(4);                     // R1 minimum spacing
    load_tx(8'h3C);                                    // R6/R7/R8 transmit
    for (int i = 0; i < 8; i++) frame(3, 18);
    cyc(4);
    send_byte(8'h81, 18);                              // back to receive
    frame(4, 18); frame(13, 18); frame(4, 18);         // R9 partial byte then abort
    cyc(TMO + 10);
    send_byte(8'h7E, 18);
    load_tx(8'hF0);
    frame(3, 18); frame(3, 18); frame(3, 18);          // R9 partial transmit aborted
    cyc(TMO + 10);
    for (int n = 0; n < 400; n++) begin               // R2/R10 random spacing incl. timeout edge
      int lo, per;
      lo = 2 + ($urandom % 13);
      per = lo + 1 + ($urandom % 45);
      rx_ready = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) begin
        tx_data = 8'($urandom); tx_valid = 1'b1; cyc(1 + $urandom % 3); tx_valid = 1'b0;
      end
      frame(lo, per);
    end
    rx_ready = 1'b1;
    cyc(TMO + 20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule